// File: doc/BRIEF.md
# Brain-Float to Single-Precision Widening Unit

This unit turns one 16-bit brain-float operand into its exact IEEE single-precision equivalent. It has two operand modes. In scalar mode the operand comes from a 64-bit floating-point register image. The unit checks that the image is correctly NaN-boxed and writes back a 64-bit image with the 32-bit result boxed in the upper half. In vector mode the operand is a raw 16-bit element taken from the low bits of the input. The result is a raw 32-bit element, and the upper half of the output is cleared.

The two formats share the same exponent width and bias. Every non-NaN value, including subnormals, zeros and infinities, therefore widens by appending sixteen zero fraction bits, and no rounding takes place. NaN inputs produce the canonical quiet single-precision NaN. A signalling NaN also raises the invalid flag. One operand is accepted on any cycle, and the registered result appears one clock later.

Top module: `bf16_widen_unit`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `result` is 0 and `exc_flags` is 0. An operand accepted with `in_valid`=1 at a rising edge appears on `result`/`exc_flags` after that edge, with `out_valid`=1 for exactly that cycle.
- R2: For a zero, normal or infinite operand (exponent field bits 14:7 not all ones, or fraction bits 6:0 zero), `result[31:0]` equals the 16-bit operand followed by 16 zero bits.
- R3: A subnormal operand (exponent field zero, fraction nonzero) widens to the single-precision subnormal `{operand,16'h0000}`, keeping its sign.
- R4: Any NaN operand (exponent field all ones, fraction nonzero) gives `result[31:0]` = 32'h7FC00000, whatever its sign or payload.
- R5: The invalid flag `exc_flags[4]` is 1 only for a signalling NaN operand (NaN with fraction bit 6 clear). Quiet NaNs and all other values leave it 0.
- R6: `exc_flags[3:0]` (divide-by-zero, overflow, underflow, inexact in descending order) are always 0.
- R7: In scalar mode (`vec_mode`=0) `result[63:32]` is all ones.
- R8: In scalar mode an operand is used only if `src[63:16]` are all ones. Otherwise it is replaced by the quiet NaN 16'h7FC0, so the result is the canonical NaN with no invalid flag, even when `src[15:0]` encodes a signalling NaN.
- R9: In vector mode (`vec_mode`=1) the operand is `src[15:0]`, `src[63:16]` have no effect, and `result[63:32]` is zero.
- R10: `rnd_mode` has no effect on `result` or `exc_flags`.
- R11: While `in_valid` is 0, `result` and `exc_flags` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| vec_mode | input | 1 | 1: raw vector element, 0: boxed scalar register |
| rnd_mode | input | 3 | Rounding mode, accepted but unused |
| src | input | 64 | Source register image or element in bits 15:0 |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 64 | Widened value, boxed or raw |
| exc_flags | output | 5 | {invalid, div-by-zero, overflow, underflow, inexact} |

## Verification
The only state in the unit is the output register. A wrong capture or a wrong hold is therefore visible on `result` in the cycle after the operand, or in the first idle cycle that follows. A misclassified operand shows up in that same cycle, either as a non-canonical NaN pattern, as a stray invalid flag, or as a boxed value where canonical NaN was due. The scoreboard pairs each accepted operand with the very next `out_valid` cycle. It also compares the held value during idle gaps, so a single wrong cycle cannot slip through.

// File: rtl/bfw_pkg.sv
package bfw_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } fp_class_e;

  localparam int FLAG_INVALID = 4;
  localparam int FLAG_COUNT   = 5;
endpackage

// File: rtl/bfw_box_check.sv
module bfw_box_check #(
  parameter int REG_W = 64,
  parameter int EXP_W = 8,
  parameter int MAN_W = 7
) (
  input  logic [REG_W-1:0]       reg_val,
  input  logic                   bypass,
  output logic [EXP_W+MAN_W:0]   op
);
  localparam int OP_W = 1 + EXP_W + MAN_W;
  localparam logic [OP_W-1:0] QUIET_PAT =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic boxed_ok;

  generate
    if (REG_W > OP_W) begin : g_wide
      assign boxed_ok = &reg_val[REG_W-1:OP_W];
    end else begin : g_flat
      assign boxed_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    if (bypass || boxed_ok) op = reg_val[OP_W-1:0];
    else                    op = QUIET_PAT;
  end
endmodule

// File: rtl/bfw_classify.sv
module bfw_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 7
) (
  input  logic [EXP_W+MAN_W:0] op,
  output bfw_pkg::fp_class_e   cls
);
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] fr;

  assign ex = op[EXP_W+MAN_W-1:MAN_W];
  assign fr = op[MAN_W-1:0];

  always_comb begin
    if (ex == '0)
      cls = (fr == '0) ? bfw_pkg::CLS_ZERO : bfw_pkg::CLS_SUB;
    else if (ex == '1) begin
      if (fr == '0)            cls = bfw_pkg::CLS_INF;
      else if (fr[MAN_W-1])    cls = bfw_pkg::CLS_QNAN;
      else                     cls = bfw_pkg::CLS_SNAN;
    end else
      cls = bfw_pkg::CLS_NORM;
  end
endmodule

// File: rtl/bfw_widen_core.sv
module bfw_widen_core #(
  parameter int EXP_W  = 8,
  parameter int MAN_IN = 7,
  parameter int MAN_OUT = 23
) (
  input  logic [EXP_W+MAN_IN:0]  op,
  input  bfw_pkg::fp_class_e     cls,
  output logic [EXP_W+MAN_OUT:0] wide,
  output logic                   invalid
);
  localparam int PAD_W = MAN_OUT - MAN_IN;
  localparam logic [EXP_W+MAN_OUT:0] CANON =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_OUT-1){1'b0}}};

  always_comb begin
    invalid = 1'b0;
    case (cls)
      bfw_pkg::CLS_QNAN: wide = CANON;
      bfw_pkg::CLS_SNAN: begin
        wide    = CANON;
        invalid = 1'b1;
      end
      default: wide = {op, {PAD_W{1'b0}}};
    endcase
  end
endmodule

// File: rtl/bf16_widen_unit.sv
module bf16_widen_unit #(
  parameter int REG_W   = 64,
  parameter int EXP_W   = 8,
  parameter int MAN_IN  = 7,
  parameter int MAN_OUT = 23
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic                          vec_mode,
  input  logic [2:0]                    rnd_mode,
  input  logic [REG_W-1:0]              src,
  output logic                          out_valid,
  output logic [REG_W-1:0]              result,
  output logic [bfw_pkg::FLAG_COUNT-1:0] exc_flags
);
  localparam int OP_W   = 1 + EXP_W + MAN_IN;
  localparam int WIDE_W = 1 + EXP_W + MAN_OUT;
  localparam int HI_W   = REG_W - WIDE_W;
  localparam logic [WIDE_W-1:0] CANON_W =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_OUT-1){1'b0}}};

  logic [OP_W-1:0]      op;
  bfw_pkg::fp_class_e   cls;
  logic [WIDE_W-1:0]    wide;
  logic                 invalid;
  logic [REG_W-1:0]     packed_res;
  logic [bfw_pkg::FLAG_COUNT-1:0] flags_nxt;

  bfw_box_check #(.REG_W(REG_W), .EXP_W(EXP_W), .MAN_W(MAN_IN)) u_box (
    .reg_val(src), .bypass(vec_mode), .op(op)
  );

  bfw_classify #(.EXP_W(EXP_W), .MAN_W(MAN_IN)) u_cls (
    .op(op), .cls(cls)
  );

  bfw_widen_core #(.EXP_W(EXP_W), .MAN_IN(MAN_IN), .MAN_OUT(MAN_OUT)) u_core (
    .op(op), .cls(cls), .wide(wide), .invalid(invalid)
  );

  generate
    if (HI_W > 0) begin : g_box
      assign packed_res = {(vec_mode ? {HI_W{1'b0}} : {HI_W{1'b1}}), wide};
    end else begin : g_nobox
      assign packed_res = wide[REG_W-1:0];
    end
  endgenerate

  always_comb begin
    flags_nxt = '0;
    flags_nxt[bfw_pkg::FLAG_INVALID] = invalid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      exc_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= packed_res;
        exc_flags <= flags_nxt;
      end
    end
  end

  // R1: one-cycle handshake
  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R6: exact conversion never raises the other flags
  assert_exact_flags_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (exc_flags[3:0] == 4'b0000));
  // R4: any NaN on the output is canonical
  assert_nan_canon_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && result[WIDE_W-2 -: EXP_W] == '1 && result[MAN_OUT-1:0] != '0)
      |-> (result[WIDE_W-1:0] == CANON_W));
  // R5: invalid only goes with the NaN result
  assert_invalid_nan_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && exc_flags[bfw_pkg::FLAG_INVALID]) |-> (result[WIDE_W-1:0] == CANON_W));
  // R7 / R9: upper half depends on mode
  assert_scalar_box_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !vec_mode) |=> (result[REG_W-1:WIDE_W] == '1));
  assert_vec_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vec_mode) |=> (result[REG_W-1:WIDE_W] == '0));
  // R10: changing only the rounding mode leaves the output unchanged
  assert_rm_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && $past(in_valid) && $stable(src) && $stable(vec_mode) && !$stable(rnd_mode))
      |=> ($stable(result) && $stable(exc_flags)));
  // R11: hold while idle
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(exc_flags)));
endmodule

// File: tb/tb_bf16_widen_unit.sv
module tb_bf16_widen_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        vec_mode;
  logic [2:0]  rnd_mode;
  logic [63:0] src;
  logic        out_valid;
  logic [63:0] result;
  logic [4:0]  exc_flags;

  always #4 clk = ~clk;

  bf16_widen_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .vec_mode(vec_mode),
    .rnd_mode(rnd_mode), .src(src), .out_valid(out_valid),
    .result(result), .exc_flags(exc_flags)
  );

  typedef struct {
    logic [63:0] res;
    logic [4:0]  flg;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          finished = 0;
  logic [63:0] last_res;
  logic [4:0]  last_flg;

  localparam logic [63:0] BOX = 64'hFFFF_FFFF_FFFF_0000;

  function automatic exp_t model(input logic vm, input logic [63:0] s, input string tag);
    exp_t e;
    logic [15:0] op;
    logic nan, snan;
    op   = (!vm && s[63:16] != 48'hFFFF_FFFF_FFFF) ? 16'h7FC0 : s[15:0];
    nan  = (op[14:7] == 8'hFF) && (op[6:0] != 7'd0);
    snan = nan && !op[6];
    e.res[31:0]  = nan ? 32'h7FC0_0000 : {op, 16'h0000};
    e.res[63:32] = vm ? 32'h0 : 32'hFFFF_FFFF;
    e.flg = {snan, 4'b0000};
    e.tag = tag;
    return e;
  endfunction

  task automatic check(input string tag, input logic [63:0] ar, input logic [63:0] er,
                       input logic [4:0] af, input logic [4:0] ef);
    n_checks++;
    if (ar !== er || af !== ef) begin
      n_fail++;
      $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b", tag, ar, af, er, ef);
    end
  endtask

  task automatic drive(input logic vm, input logic [2:0] rm, input logic [63:0] s,
                       input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    vec_mode = vm;
    rnd_mode = rm;
    src      = s;
    sb.push_back(model(vm, s, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src      = 64'hDEAD_BEEF_0BAD_F00D;
    end
  endtask

  // monitor: pops one expected item per valid result, checks hold when idle
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R1: result %h with no pending operand", result);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, result, e.res, exc_flags, e.flg);
          last_res = e.res;
          last_flg = e.flg;
        end
      end else if (last_res !== 64'hx) begin
        check("R11 hold", result, last_res, exc_flags, last_flg);
      end
    end
  end

  initial begin
    last_res = 64'hx;
    last_flg = 5'hx;
    rst = 1'b1; in_valid = 1'b0; vec_mode = 1'b0; rnd_mode = 3'd0; src = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", result, 64'h0, exc_flags, 5'h0);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: out_valid=%b expected 0", out_valid);
    end
    rst = 1'b0;

    // R2 normal, zero, infinity (scalar)
    drive(1'b0, 3'd0, BOX | 64'h3F80, "R2 one");
    drive(1'b0, 3'd0, BOX | 64'hC049, "R2 negative normal");
    drive(1'b0, 3'd0, BOX | 64'h8000, "R2 negative zero");
    drive(1'b0, 3'd0, BOX | 64'h7F80, "R2 +inf");
    drive(1'b0, 3'd0, BOX | 64'hFF80, "R2 -inf");
    drive(1'b0, 3'd0, BOX | 64'h7F7F, "R2 max normal");
    // R3 subnormals
    drive(1'b0, 3'd0, BOX | 64'h0001, "R3 min subnormal");
    drive(1'b0, 3'd0, BOX | 64'h807F, "R3 neg max subnormal");
    // R4/R5 NaNs
    drive(1'b0, 3'd0, BOX | 64'h7FC1, "R4 qnan payload");
    drive(1'b0, 3'd0, BOX | 64'hFFFF, "R4 neg qnan");
    drive(1'b0, 3'd0, BOX | 64'h7F81, "R5 snan");
    drive(1'b0, 3'd0, BOX | 64'hFFBF, "R5 neg snan");
    idle(2);
    // R8 bad boxing
    drive(1'b0, 3'd0, 64'h0000_0000_0000_3F80, "R8 unboxed zeros");
    drive(1'b0, 3'd0, 64'hFFFF_FFFF_FFFE_7F81, "R8 unboxed snan no invalid");
    drive(1'b0, 3'd0, 64'h7FFF_FFFF_FFFF_4000, "R8 top bit clear");
    // R9 vector mode
    drive(1'b1, 3'd0, 64'h1234_5678_9ABC_3F80, "R9 vec upper ignored");
    drive(1'b1, 3'd0, 64'h0000_0000_0000_7F81, "R9 vec snan");
    drive(1'b1, 3'd0, 64'h0000_0000_0000_0003, "R9 vec subnormal");
    drive(1'b1, 3'd0, BOX | 64'hC000, "R7 R9 vec boxed input");
    // R10 rounding modes on an input that would round if anything did
    for (int r = 0; r < 8; r++) drive(1'b0, 3'(r), BOX | 64'h3FAB, "R10 rounding mode");
    for (int r = 0; r < 8; r++) drive(1'b1, 3'(r), 64'h0000_0000_0000_807F, "R10 vec rounding mode");
    idle(3);
    // R6/R7 sweep of all exponent/fraction edges in both modes
    for (int e = 0; e < 256; e += 51) begin
      drive(1'b0, 3'd0, BOX | {48'h0, 1'b1, 8'(e), 7'h40}, "R6 R7 sweep");
      drive(1'b1, 3'd0, {48'h0, 1'b0, 8'(e), 7'h01}, "R6 sweep vec");
    end
    idle(4);
    finished = 1;
    n_checks++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R1: %0d results missing expected 0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule